// File: doc/BRIEF.md
# CAN Nominal Bit Timing and Synchronization Unit

This unit turns a time-quantum enable into the nominal bit timing of a CAN node. Each bit has four parts: one synchronization quantum, a propagation part, a first phase part and a second phase part. A one-cycle `sample_stb` marks the point between the two phase parts, and `sample_bit` carries the receive level taken at that point. A one-cycle `bit_stb` marks the close of each synchronization quantum, which is where a bit begins.

The unit watches `rx` for recessive-to-dominant transitions, which are falling edges since recessive is 1. While `hard_sync_en` is high, such an edge restarts the bit at once. This is hard synchronization, used while the bus is idle. While `hard_sync_en` is low, the unit measures how far the edge is from the synchronization quantum. It then stretches the first phase or cuts the second phase, by no more than the jump width. The quantum prescaler, frame decoding, stuffing and error handling sit in other blocks.

In the requirements, a *tick* is a clock cycle with `tq_en` high, and it closes one time quantum. P, S1, S2 and J are the propagation, phase 1, phase 2 and jump-width lengths after clamping. Quanta within a bit are counted from 0, which is the synchronization quantum.

Top module: `can_bit_sync`

## Requirements
- R1: With no falling edge on `rx`, `bit_stb` pulses once every 1+P+S1+S2 ticks. The synchronization part is always exactly one quantum.
- R2: `sample_stb` pulses once per bit, P+S1 ticks after the tick that produced the preceding `bit_stb`, plus any phase-1 extension from R9. It never pulses together with `bit_stb`.
- R3: On a `sample_stb` pulse, `sample_bit` equals the `rx` level at the sampling tick. Between pulses, `sample_bit` holds its value.
- R4: P and S1 are taken from `prop_len` and `ph1_len` clamped into 1..8: 0 gives 1, and 9..15 give 8.
- R5: S2 is `ph2_len` clamped into max(S1, 2)..8, where 2 quanta is the fixed processing time. J is `sjw_len` clamped into 1..min(S1, 4).
- R6: A falling edge seen at a tick while `hard_sync_en` is high makes the quantum that tick closes the synchronization quantum. `bit_stb` pulses after that tick, no sample is taken at that tick, and the next sample follows P+S1 ticks later.
- R7: A falling edge means `rx` was 1 at the previous tick and is 0 at this tick. Changes between ticks and rising edges have no effect. `rx` counts as 1 before the first tick after reset.
- R8: With `hard_sync_en` low, a falling edge at the tick that closes the synchronization quantum (quantum 0) causes no correction.
- R9: With `hard_sync_en` low, a falling edge at the tick closing quantum q, with 1 ≤ q ≤ P+S1, lengthens phase 1 of the current bit by min(q, J) quanta.
- R10: With `hard_sync_en` low, a falling edge at the tick closing a phase-2 quantum q gives d = bit length − q. If d ≤ J, that quantum becomes the synchronization quantum and `bit_stb` pulses after the tick. Otherwise the bit is shortened by J quanta.
- R11: After a correction or a hard synchronization, further falling edges with `hard_sync_en` low are ignored until a synchronization quantum is closed by normal counting.
- R12: Outputs change only in the clock cycle after a tick. Both strobes last one cycle.
- R13: During and right after reset, both strobes are 0 and `sample_bit` is 1. The first tick after reset closes a synchronization quantum, so `bit_stb` pulses after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tq_en | input | 1 | One-cycle pulse closing each time quantum |
| hard_sync_en | input | 1 | High: falling edges hard-synchronize; low: they resynchronize |
| rx | input | 1 | Receive level, already synchronized to `clk` (1 = recessive) |
| prop_len | input | SEG_W | Propagation length request in quanta |
| ph1_len | input | SEG_W | Phase 1 length request in quanta |
| ph2_len | input | SEG_W | Phase 2 length request in quanta |
| sjw_len | input | SEG_W | Jump width request in quanta |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| sample_bit | output | 1 | `rx` level captured at the last sample point |
| bit_stb | output | 1 | One-cycle strobe when a synchronization quantum closes |

## Verification
The bench uses the default parameters: 4-bit length inputs, segment limit 8, jump-width limit 4 and processing time 2. With 4-bit inputs, the requests can go below the minimum and above the maximum, so every clamp edge of R4 and R5 can be driven, including a phase 2 forced up to phase 1 or to 2 and a jump width cut to phase 1. With the jump-width limit of 4 and phase lengths up to 8, falling edges can land both within J and beyond J of the bit end. This brings both the full-correction and the partial-correction branches of R9 and R10 within reach.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  function automatic int lim(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/can_bt_cfg.sv
// Clamps the requested segment lengths into the legal ranges and registers them.
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int MAX_SEG = 8,
  parameter int MAX_SJW = 4,
  parameter int IPT_TQ  = 2,
  parameter int LW      = 4
) (
  input  logic             clk,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SEG_W-1:0] sjw_len,
  output logic [LW-1:0]    prop_q,
  output logic [LW-1:0]    ph1_q,
  output logic [LW-1:0]    ph2_q,
  output logic [LW-1:0]    sjw_q
);

  int p_i, s1_i, s2_i, j_i;

  always_comb begin
    p_i  = lim(int'(prop_len), 1, MAX_SEG);
    s1_i = lim(int'(ph1_len), 1, MAX_SEG);
    s2_i = lim(int'(ph2_len), imax(s1_i, IPT_TQ), MAX_SEG);
    j_i  = lim(int'(sjw_len), 1, imin(s1_i, MAX_SJW));
  end

  // Lengths are reloaded every cycle; they take effect one cycle after a change.
  always_ff @(posedge clk) begin
    prop_q <= p_i[LW-1:0];
    ph1_q  <= s1_i[LW-1:0];
    ph2_q  <= s2_i[LW-1:0];
    sjw_q  <= j_i[LW-1:0];
  end

endmodule

// File: rtl/can_bt_edge.sv
// Finds recessive-to-dominant transitions between consecutive quantum ticks.
module can_bt_edge (
  input  logic clk,
  input  logic rst,
  input  logic tq_en,
  input  logic rx,
  output logic fall
);

  logic rx_prev;

  always_ff @(posedge clk) begin
    if (rst)        rx_prev <= 1'b1;
    else if (tq_en) rx_prev <= rx;
  end

  assign fall = tq_en && rx_prev && !rx;

endmodule

// File: rtl/can_bt_core.sv
// Segment sequencer with hard synchronization and resynchronization.
module can_bt_core
  import can_bt_pkg::*;
#(
  parameter int LW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tq_en,
  input  logic          fall,
  input  logic          hs_en,
  input  logic          rx,
  input  logic [LW-1:0] prop_q,
  input  logic [LW-1:0] ph1_q,
  input  logic [LW-1:0] ph2_q,
  input  logic [LW-1:0] sjw_q,
  output logic          bit_stb,
  output logic          sample_stb,
  output logic          sample_bit
);

  seg_e          seg, n_seg;
  logic [CW-1:0] left, n_left;   // quanta left in the segment after the current one
  logic [CW-1:0] pos, n_pos;     // index of the current quantum in the bit
  logic [CW-1:0] ext, n_ext;     // phase 1 extension booked during propagation
  logic          used, n_used;   // correction already spent in this bit
  logic [CW-1:0] prop_x, ph1_x, ph2_x, sjw_x, amt, work_left, neg_e;
  logic          do_hard, do_res, rebase, smp_now;

  assign prop_x  = CW'(prop_q);
  assign ph1_x   = CW'(ph1_q);
  assign ph2_x   = CW'(ph2_q);
  assign sjw_x   = CW'(sjw_q);
  assign amt     = (pos >= sjw_x) ? sjw_x : pos;
  assign neg_e   = left + CW'(1);
  assign do_hard = fall && hs_en;
  assign do_res  = fall && !hs_en && !used && (seg != SEG_SYNC);

  always_comb begin
    n_seg     = seg;
    n_left    = left;
    n_pos     = pos + CW'(1);
    n_ext     = ext;
    n_used    = used;
    work_left = left;
    rebase    = 1'b0;
    if (do_hard) begin
      rebase = 1'b1;
    end else if (do_res) begin
      n_used = 1'b1;
      case (seg)
        SEG_PROP: n_ext = amt;
        SEG_PH1:  work_left = left + amt;
        SEG_PH2: begin
          if (neg_e <= sjw_x) rebase = 1'b1;
          else                work_left = left - sjw_x;
        end
        default: ;
      endcase
    end
    smp_now = !rebase && (seg == SEG_PH1) && (work_left == '0);
    if (rebase) begin
      n_seg  = SEG_PROP;
      n_left = prop_x - CW'(1);
      n_pos  = CW'(1);
      n_ext  = '0;
      n_used = 1'b1;
    end else if (work_left == '0) begin
      case (seg)
        SEG_SYNC: begin
          n_seg  = SEG_PROP;
          n_left = prop_x - CW'(1);
          n_used = 1'b0;
        end
        SEG_PROP: begin
          n_seg  = SEG_PH1;
          n_left = ph1_x + n_ext - CW'(1);
        end
        SEG_PH1: begin
          n_seg  = SEG_PH2;
          n_left = ph2_x - CW'(1);
        end
        default: begin
          n_seg  = SEG_SYNC;
          n_left = '0;
          n_pos  = '0;
          n_ext  = '0;
        end
      endcase
    end else begin
      n_left = work_left - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg        <= SEG_SYNC;
      left       <= '0;
      pos        <= '0;
      ext        <= '0;
      used       <= 1'b0;
      bit_stb    <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
    end else begin
      bit_stb    <= tq_en && (rebase || (seg == SEG_SYNC));
      sample_stb <= tq_en && smp_now;
      if (tq_en) begin
        seg  <= n_seg;
        left <= n_left;
        pos  <= n_pos;
        ext  <= n_ext;
        used <= n_used;
        if (smp_now) sample_bit <= rx;
      end
    end
  end

endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync #(
  parameter int SEG_W   = 4,
  parameter int MAX_SEG = 8,
  parameter int MAX_SJW = 4,
  parameter int IPT_TQ  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_en,
  input  logic             hard_sync_en,
  input  logic             rx,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SEG_W-1:0] sjw_len,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_stb
);

  localparam int LW = $clog2(MAX_SEG + 1);
  localparam int CW = $clog2(3 * MAX_SEG + MAX_SJW + 2);

  logic [LW-1:0] prop_q, ph1_q, ph2_q, sjw_q;
  logic          fall;

  can_bt_cfg #(
    .SEG_W(SEG_W), .MAX_SEG(MAX_SEG), .MAX_SJW(MAX_SJW), .IPT_TQ(IPT_TQ), .LW(LW)
  ) cfg_i (
    .clk(clk), .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len),
    .sjw_len(sjw_len), .prop_q(prop_q), .ph1_q(ph1_q), .ph2_q(ph2_q), .sjw_q(sjw_q)
  );

  can_bt_edge edge_i (
    .clk(clk), .rst(rst), .tq_en(tq_en), .rx(rx), .fall(fall)
  );

  can_bt_core #(.LW(LW), .CW(CW)) core_i (
    .clk(clk), .rst(rst), .tq_en(tq_en), .fall(fall), .hs_en(hard_sync_en), .rx(rx),
    .prop_q(prop_q), .ph1_q(ph1_q), .ph2_q(ph2_q), .sjw_q(sjw_q),
    .bit_stb(bit_stb), .sample_stb(sample_stb), .sample_bit(sample_bit)
  );

endmodule

// File: rtl/can_bit_sync_chk.sv
module can_bit_sync_chk (
  input logic clk,
  input logic rst,
  input logic tq_en,
  input logic rx,
  input logic sample_stb,
  input logic sample_bit,
  input logic bit_stb
);

  logic smp_seen;

  always_ff @(posedge clk) begin
    if (rst)             smp_seen <= 1'b0;
    else if (bit_stb)    smp_seen <= 1'b0;
    else if (sample_stb) smp_seen <= 1'b1;
  end

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    (sample_stb || bit_stb) |-> $past(tq_en)); // R12
  AST_STROBES_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_stb)); // R2
  AST_ONE_SAMPLE_PER_BIT: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> !smp_seen); // R2
  AST_SAMPLE_TAKES_RX: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (sample_bit == $past(rx))); // R3
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> $stable(sample_bit)); // R3
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sample_stb && !bit_stb && sample_bit)); // R13

endmodule

bind can_bit_sync can_bit_sync_chk chk_i (.*);

// File: tb/can_bit_sync_tb_top.sv
`timescale 1ns/1ps
module can_bit_sync_tb_top;

  localparam int SEG_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tq_en = 1'b0;
  logic hard_sync_en = 1'b0;
  logic rx = 1'b1;
  logic [SEG_W-1:0] prop_len = '0, ph1_len = '0, ph2_len = '0, sjw_len = '0;
  logic sample_stb, sample_bit, bit_stb;

  always #2 clk = ~clk;

  can_bit_sync #(.SEG_W(SEG_W)) dut_i (
    .clk(clk), .rst(rst), .tq_en(tq_en), .hard_sync_en(hard_sync_en), .rx(rx),
    .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw_len(sjw_len),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .bit_stb(bit_stb)
  );

  int    n_chk = 0, n_bad = 0;
  string tag = "R13";
  bit    done = 0;

  // clamped configuration (R4, R5) and reference timing state
  int cP, cS1, cS2, cJ;
  int m_q, m_ph1, m_len;
  bit m_used, m_prev;
  bit e_bit, e_smp, e_sbit;

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic set_cfg(input int p, input int s1, input int s2, input int j);
    prop_len = SEG_W'(p); ph1_len = SEG_W'(s1); ph2_len = SEG_W'(s2); sjw_len = SEG_W'(j);
    cP  = clampi(p, 1, 8);
    cS1 = clampi(s1, 1, 8);
    cS2 = clampi(s2, (cS1 > 2) ? cS1 : 2, 8);
    cJ  = clampi(j, 1, (cS1 < 4) ? cS1 : 4);
  endtask

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL [%s] %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_q = 0; m_ph1 = cS1; m_len = 1 + cP + cS1 + cS2;
    m_used = 0; m_prev = 1; e_sbit = 1; e_bit = 0; e_smp = 0;
  endtask

  // expected outputs after one tick, from the requirements
  task automatic model_tick(input bit rxv, input bit hs);
    bit fall, rebase;
    int amt, d;
    fall = m_prev && !rxv;
    m_prev = rxv;
    rebase = 0; e_bit = 0; e_smp = 0;
    if (fall && hs) rebase = 1;                          // R6
    else if (fall && !m_used && m_q != 0) begin          // R8, R11
      m_used = 1;
      if (m_q <= cP + m_ph1) begin                       // R9
        amt = (m_q < cJ) ? m_q : cJ;
        m_ph1 += amt; m_len += amt;
      end else begin                                     // R10
        d = m_len - m_q;
        if (d <= cJ) rebase = 1;
        else m_len -= cJ;
      end
    end
    if (rebase) begin
      e_bit = 1; m_q = 1; m_ph1 = cS1; m_len = 1 + cP + cS1 + cS2; m_used = 1;
    end else begin
      if (m_q == 0) begin e_bit = 1; m_used = 0; end     // R1
      if (m_q == cP + m_ph1) begin e_smp = 1; e_sbit = rxv; end  // R2, R3
      m_q++;
      if (m_q == m_len) begin m_q = 0; m_ph1 = cS1; m_len = 1 + cP + cS1 + cS2; end
    end
  endtask

  // one clock: drive at negedge, compare after the posedge
  task automatic step(input bit tick, input bit rxv);
    string sv;
    tq_en = tick; rx = rxv;
    if (tick) model_tick(rxv, hard_sync_en);
    else begin e_bit = 0; e_smp = 0; end
    @(posedge clk);
    @(negedge clk);
    sv = tag;
    if (!tick) tag = {sv, " R12"};
    check("bit_stb", bit_stb, e_bit);
    check("sample_stb", sample_stb, e_smp);
    check("sample_bit", sample_bit, e_sbit);
    tag = sv;
  endtask

  task automatic do_reset();
    tag = "R13";
    rst = 1; tq_en = 0; rx = 1;
    repeat (3) @(negedge clk);
    check("bit_stb in reset", bit_stb, 0);
    check("sample_stb in reset", sample_stb, 0);
    check("sample_bit in reset", sample_bit, 1);
    rst = 0;
    model_reset();
    step(0, 1);
    step(1, 1);   // first tick closes the sync quantum (R13)
  endtask

  task automatic run(input string t, input int ticks, input int toggle_pct, input bit hs);
    bit r;
    tag = t;
    hard_sync_en = hs;
    r = rx;
    for (int i = 0; i < ticks; i++) begin
      for (int g = $urandom_range(0, 2); g > 0; g--) step(0, r);
      if ($urandom_range(0, 99) < toggle_pct) r = ~r;
      step(1, r);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    @(negedge clk);
    // nominal timing, idle bus
    set_cfg(3, 4, 4, 2);
    do_reset();
    run("R1 R2", 150, 0, 0);
    // data with resynchronization
    do_reset();
    run("R3 R8 R9 R10 R11", 400, 18, 0);
    // hard synchronization, rising edges ignored
    do_reset();
    run("R6 R7", 300, 20, 1);
    // clamping at low and high limits
    set_cfg(0, 12, 1, 9);
    do_reset();
    run("R4 R5", 150, 15, 0);
    set_cfg(15, 1, 0, 0);
    do_reset();
    run("R4 R5", 150, 15, 0);
    set_cfg(2, 6, 3, 7);
    do_reset();
    run("R5 R9 R10", 200, 15, 0);
    // random configurations, mixed modes
    for (int k = 0; k < 12; k++) begin
      set_cfg($urandom_range(0, 15), $urandom_range(0, 15),
              $urandom_range(0, 15), $urandom_range(0, 15));
      do_reset();
      run("R9 R10 R11", 250, 12, 0);
      run("R6 R7", 60, 12, 1);
      run("R8 R9 R10 R11", 150, 25, 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL [watchdog] run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule